// File: doc/BRIEF.md
# Dual-Slot Instruction Dispatch Sequencer

This block sits between an instruction fetch stream and an execute unit. Each accepted 32-bit word carries either one long operation or two short ones. The two top bits of the word choose the form. The block hands the operations one at a time to the execute side, in the order the form requires. It then picks the next program counter. The program counter counts 32-bit words, and the byte address offered to fetch is the program counter times four.

Short operations can run in three ways. In the two sequential forms, a taken branch or an exception in the first operation cancels the second. In parallel form, an operation recognised as a condition test runs first and decides whether its partner runs. Without such a test, parallel form runs left then right.

Next-PC selection has three parts built in: a zero-overhead repeat loop, an instruction-address breakpoint that redirects to a trap vector, and a halt on any exception. A halted block waits for a resume pulse.

Top module: `dual_slot_dispatch`

## Requirements
- R1: After reset, `pc` is 0xFFC0, `fetch_addr` is 0x3FF00, all four counters are zero, `ex_valid` and `halted` are low, and `in_ready` is high.
- R2: A word whose bits 31:30 are 11 issues exactly one operation. That operation carries bits 29:0 of the word, with `ex_long`=1.
- R3: The left short slot is bits 29:15 and the right short slot is bits 14:0. Shorts are zero-extended on `ex_op`, and `ex_slot` is 0 for left and 1 for right. Form 10 issues right then left; form 01 issues left then right.
- R4: In forms 10 and 01, the second short is not issued if the first returns `ex_taken` or `ex_exc`. A cancel caused by a taken branch (without an exception) adds one to `cnt_skip_branch`.
- R5: In form 00, a short is a condition test when (slot & CT_MASK) == CT_MATCH (defaults 0x7C00 and 0x3C00). If the left slot is a test, it runs first; otherwise, if the right slot is a test, it runs first. The partner is issued with `ex_pred`=1 only if the test returns `ex_cond`=1; otherwise the partner is skipped and `cnt_skip_cond` adds one.
- R6: In form 00 with no test slot, left is issued, then right. Right is not issued if left returns `ex_exc`.
- R7: When no operation of a word returned `ex_taken`, the next `pc` is `pc`+1. Otherwise it is the `ex_target` of the last taken operation of that word.
- R8: A `loop_set` pulse arms a repeat loop with start, end and count. When a word at the end address finishes without a taken branch, the count drops by one. At zero the loop disarms and `pc` steps to end+1; otherwise `pc` loads the start address.
- R9: A taken branch whose target is the loop end address goes to that address. The loop count is not changed in that word.
- R10: If `dbg_en` is high and `pc` equals `bp_addr` when a word is fetched, then when that word finishes: `trap_pc` takes the selected next PC, `trap_stat` takes `stat_in`, `stat_wr` pulses for one cycle with `stat_wdata` = `stat_in` masked to bit SM_BIT (default 15), and `pc` becomes TRAP_VEC (default 0x0040).
- R11: An operation that returns `ex_exc` sets `halted`, stops all issue and holds `pc` until a `resume` pulse. After that pulse, fetch restarts at the same `pc`.
- R12: `in_ready` is high only while the block waits for a word (never while `ex_valid` is high). Once `ex_valid` rises, it and `ex_op` stay stable until `ex_ready` is seen.
- R13: `cnt_words` counts words that finish without an exception, and `cnt_issued` counts operations accepted by the execute side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetched word offered |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Fetched instruction word for the current `pc` |
| fetch_addr | output | PC_W+2 | Byte address of the current word |
| pc | output | PC_W | Word program counter |
| ex_valid | output | 1 | Operation offered to execute |
| ex_ready | input | 1 | Execute accepts the operation and returns flags this cycle |
| ex_op | output | 30 | Operation bits (shorts zero-extended) |
| ex_long | output | 1 | Operation is long |
| ex_slot | output | 1 | 0 = left short, 1 = right short |
| ex_pred | output | 1 | Operation is the partner of a passed condition test |
| ex_taken | input | 1 | Operation changed the PC |
| ex_target | input | PC_W | New PC when taken |
| ex_cond | input | 1 | Condition-test result |
| ex_exc | input | 1 | Operation raised an exception |
| halted | output | 1 | Stopped by an exception |
| resume | input | 1 | Leave the halted state |
| loop_set | input | 1 | Arm the repeat loop |
| loop_start | input | PC_W | Loop start address |
| loop_end | input | PC_W | Loop end address |
| loop_count | input | RC_W | Iteration count, at least 1 |
| dbg_en | input | 1 | Breakpoint enable |
| bp_addr | input | PC_W | Breakpoint word address |
| stat_in | input | STAT_W | Current status word |
| stat_wr | output | 1 | Status write pulse on a trap |
| stat_wdata | output | STAT_W | Status value written on a trap |
| trap_pc | output | PC_W | Saved next PC of the last trap |
| trap_stat | output | STAT_W | Saved status of the last trap |
| cnt_words | output | CNT_W | Completed words |
| cnt_issued | output | CNT_W | Issued operations |
| cnt_skip_cond | output | CNT_W | Partners skipped by a false test |
| cnt_skip_branch | output | CNT_W | Second shorts cancelled by a taken branch |

## Verification
Some properties can be checked on every cycle: the valid/ready rules on both streams, entry into and hold of the halted state, the long form being the last operation of its word, the masking and target of a trap, and counters that never fall. Other behaviour needs a known sequence of words and responses, so only the directed scenarios show it. This covers the slot order for each form, the exact skip decisions, the last-taken-target rule, the repeat loop's iteration count and exit address, and a branch landing on the loop end without using up an iteration.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_OP1   = 2'd1,
    ST_OP2   = 2'd2,
    ST_HALT  = 2'd3
  } dsd_state_e;

  typedef enum logic [1:0] {
    MODE_ONE  = 2'd0,
    MODE_SEQ  = 2'd1,
    MODE_PRED = 2'd2,
    MODE_PAR  = 2'd3
  } dsd_mode_e;

  localparam logic [1:0] FMT_LONG = 2'b11;
  localparam logic [1:0] FMT_RL   = 2'b10;
  localparam logic [1:0] FMT_LR   = 2'b01;
  localparam logic [1:0] FMT_PAR  = 2'b00;

  localparam logic SLOT_LEFT  = 1'b0;
  localparam logic SLOT_RIGHT = 1'b1;
endpackage

// File: rtl/dsd_slot_plan.sv
module dsd_slot_plan
  import dsd_pkg::*;
#(
  parameter int SLOT_W = 15,
  parameter logic [SLOT_W-1:0] CT_MASK  = 15'h7C00,
  parameter logic [SLOT_W-1:0] CT_MATCH = 15'h3C00,
  localparam int OP_W = 2 * SLOT_W,
  localparam int WORD_W = OP_W + 2
) (
  input  logic [WORD_W-1:0] word,
  output logic [OP_W-1:0]   op1,
  output logic [OP_W-1:0]   op2,
  output logic              slot1,
  output logic              slot2,
  output logic              long1,
  output logic              pred2,
  output dsd_mode_e         mode
);
  logic [SLOT_W-1:0] left_s, right_s;
  logic [OP_W-1:0]   left_x, right_x;
  logic              left_ct, right_ct;

  assign left_s  = word[OP_W-1:SLOT_W];
  assign right_s = word[SLOT_W-1:0];
  assign left_x  = {{SLOT_W{1'b0}}, left_s};
  assign right_x = {{SLOT_W{1'b0}}, right_s};
  assign left_ct  = (left_s & CT_MASK) == CT_MATCH;
  assign right_ct = (right_s & CT_MASK) == CT_MATCH;

  always_comb begin
    op1   = left_x;
    op2   = right_x;
    slot1 = SLOT_LEFT;
    slot2 = SLOT_RIGHT;
    long1 = 1'b0;
    pred2 = 1'b0;
    mode  = MODE_PAR;
    unique case (word[WORD_W-1:WORD_W-2])
      FMT_LONG: begin
        op1   = word[OP_W-1:0];
        long1 = 1'b1;
        mode  = MODE_ONE;
      end
      FMT_RL: begin
        op1   = right_x;
        op2   = left_x;
        slot1 = SLOT_RIGHT;
        slot2 = SLOT_LEFT;
        mode  = MODE_SEQ;
      end
      FMT_LR: begin
        mode = MODE_SEQ;
      end
      default: begin
        if (left_ct) begin
          mode  = MODE_PRED;
          pred2 = 1'b1;
        end else if (right_ct) begin
          op1   = right_x;
          op2   = left_x;
          slot1 = SLOT_RIGHT;
          slot2 = SLOT_LEFT;
          mode  = MODE_PRED;
          pred2 = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/dsd_next_pc.sv
module dsd_next_pc #(
  parameter int PC_W = 16,
  parameter int RC_W = 16
) (
  input  logic [PC_W-1:0] pc,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_tgt,
  input  logic            rpt_on,
  input  logic [PC_W-1:0] rpt_start,
  input  logic [PC_W-1:0] rpt_end,
  input  logic [RC_W-1:0] rpt_left,
  output logic [PC_W-1:0] npc,
  output logic            rpt_dec,
  output logic            rpt_done
);
  localparam logic [PC_W-1:0] ONE_PC = {{(PC_W-1){1'b0}}, 1'b1};
  localparam logic [RC_W-1:0] ONE_RC = {{(RC_W-1){1'b0}}, 1'b1};

  logic at_end;
  assign at_end = rpt_on && (pc == rpt_end);

  always_comb begin
    rpt_dec  = 1'b0;
    rpt_done = 1'b0;
    npc      = pc + ONE_PC;
    if (br_taken) begin
      npc = br_tgt;
    end else if (at_end) begin
      rpt_dec = 1'b1;
      if (rpt_left == ONE_RC) begin
        rpt_done = 1'b1;
      end else begin
        npc = rpt_start;
      end
    end
  end
endmodule

// File: rtl/dsd_counters.sv
module dsd_counters #(
  parameter int NUM   = 4,
  parameter int CNT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM-1:0]            inc,
  output logic [NUM-1:0][CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[g] <= '0;
      end else if (inc[g]) begin
        cnt[g] <= cnt[g] + STEP;
      end
    end
  end
endmodule

// File: rtl/dual_slot_dispatch.sv
module dual_slot_dispatch
  import dsd_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int RC_W   = 16,
  parameter int STAT_W = 16,
  parameter int CNT_W  = 32,
  parameter int SLOT_W = 15,
  parameter int SM_BIT = 15,
  parameter logic [PC_W-1:0] RESET_PC = 16'hFFC0,
  parameter logic [PC_W-1:0] TRAP_VEC = 16'h0040,
  parameter logic [SLOT_W-1:0] CT_MASK  = 15'h7C00,
  parameter logic [SLOT_W-1:0] CT_MATCH = 15'h3C00,
  localparam int OP_W = 2 * SLOT_W,
  localparam int WORD_W = OP_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic [PC_W+1:0]   fetch_addr,
  output logic [PC_W-1:0]   pc,
  output logic              ex_valid,
  input  logic              ex_ready,
  output logic [OP_W-1:0]   ex_op,
  output logic              ex_long,
  output logic              ex_slot,
  output logic              ex_pred,
  input  logic              ex_taken,
  input  logic [PC_W-1:0]   ex_target,
  input  logic              ex_cond,
  input  logic              ex_exc,
  output logic              halted,
  input  logic              resume,
  input  logic              loop_set,
  input  logic [PC_W-1:0]   loop_start,
  input  logic [PC_W-1:0]   loop_end,
  input  logic [RC_W-1:0]   loop_count,
  input  logic              dbg_en,
  input  logic [PC_W-1:0]   bp_addr,
  input  logic [STAT_W-1:0] stat_in,
  output logic              stat_wr,
  output logic [STAT_W-1:0] stat_wdata,
  output logic [PC_W-1:0]   trap_pc,
  output logic [STAT_W-1:0] trap_stat,
  output logic [CNT_W-1:0]  cnt_words,
  output logic [CNT_W-1:0]  cnt_issued,
  output logic [CNT_W-1:0]  cnt_skip_cond,
  output logic [CNT_W-1:0]  cnt_skip_branch
);
  localparam logic [STAT_W-1:0] SM_MASK = STAT_W'(1) << SM_BIT;
  localparam logic [RC_W-1:0]   RC_ONE  = {{(RC_W-1){1'b0}}, 1'b1};

  dsd_state_e st;
  dsd_mode_e  mode_q, mode_d;
  logic [OP_W-1:0] op1_q, op2_q, op1_d, op2_d;
  logic slot1_q, slot2_q, long1_q, pred2_q, bp_q;
  logic slot1_d, slot2_d, long1_d, pred2_d;
  logic br_q;
  logic [PC_W-1:0] tgt_q;

  logic            rpt_on;
  logic [PC_W-1:0] rpt_start, rpt_end;
  logic [RC_W-1:0] rpt_left;

  logic            accept, take_word, last1, finish, to_op2;
  logic            br_now;
  logic [PC_W-1:0] tgt_now, npc;
  logic            rpt_dec, rpt_done;
  logic [3:0]      cnt_inc;
  logic [3:0][CNT_W-1:0] cnt_vec;

  dsd_slot_plan #(
    .SLOT_W(SLOT_W), .CT_MASK(CT_MASK), .CT_MATCH(CT_MATCH)
  ) u_plan (
    .word(in_word), .op1(op1_d), .op2(op2_d), .slot1(slot1_d),
    .slot2(slot2_d), .long1(long1_d), .pred2(pred2_d), .mode(mode_d)
  );

  assign in_ready   = (st == ST_FETCH);
  assign halted     = (st == ST_HALT);
  assign ex_valid   = (st == ST_OP1) || (st == ST_OP2);
  assign ex_op      = (st == ST_OP2) ? op2_q : op1_q;
  assign ex_slot    = (st == ST_OP2) ? slot2_q : slot1_q;
  assign ex_long    = (st == ST_OP1) && long1_q;
  assign ex_pred    = (st == ST_OP2) && pred2_q;
  assign fetch_addr = {pc, 2'b00};

  assign take_word = in_valid && in_ready;
  assign accept    = ex_valid && ex_ready;

  // a first operation ends the word on its own in these cases
  always_comb begin
    last1 = 1'b0;
    unique case (mode_q)
      MODE_ONE:  last1 = 1'b1;
      MODE_SEQ:  last1 = ex_taken;
      MODE_PRED: last1 = !ex_cond;
      default:   last1 = 1'b0;
    endcase
  end

  assign finish = accept && !ex_exc && ((st == ST_OP2) || last1);
  assign to_op2 = accept && !ex_exc && (st == ST_OP1) && !last1;
  assign br_now  = br_q || (accept && ex_taken);
  assign tgt_now = (accept && ex_taken) ? ex_target : tgt_q;

  dsd_next_pc #(.PC_W(PC_W), .RC_W(RC_W)) u_npc (
    .pc(pc), .br_taken(br_now), .br_tgt(tgt_now), .rpt_on(rpt_on),
    .rpt_start(rpt_start), .rpt_end(rpt_end), .rpt_left(rpt_left),
    .npc(npc), .rpt_dec(rpt_dec), .rpt_done(rpt_done)
  );

  // sequencing state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_FETCH;
      mode_q  <= MODE_ONE;
      op1_q   <= '0;
      op2_q   <= '0;
      slot1_q <= 1'b0;
      slot2_q <= 1'b0;
      long1_q <= 1'b0;
      pred2_q <= 1'b0;
      bp_q    <= 1'b0;
      br_q    <= 1'b0;
      tgt_q   <= '0;
    end else begin
      unique case (st)
        ST_FETCH: if (take_word) begin
          st      <= ST_OP1;
          mode_q  <= mode_d;
          op1_q   <= op1_d;
          op2_q   <= op2_d;
          slot1_q <= slot1_d;
          slot2_q <= slot2_d;
          long1_q <= long1_d;
          pred2_q <= pred2_d;
          bp_q    <= dbg_en && (pc == bp_addr);
          br_q    <= 1'b0;
        end
        ST_OP1, ST_OP2: if (accept) begin
          if (ex_exc)      st <= ST_HALT;
          else if (to_op2) st <= ST_OP2;
          else             st <= ST_FETCH;
          if (ex_taken) begin
            br_q  <= 1'b1;
            tgt_q <= ex_target;
          end
        end
        default: if (resume) st <= ST_FETCH;
      endcase
    end
  end

  // program counter and breakpoint trap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= RESET_PC;
      stat_wr    <= 1'b0;
      stat_wdata <= '0;
      trap_pc    <= '0;
      trap_stat  <= '0;
    end else begin
      stat_wr <= finish && bp_q;
      if (finish) begin
        if (bp_q) begin
          pc         <= TRAP_VEC;
          trap_pc    <= npc;
          trap_stat  <= stat_in;
          stat_wdata <= stat_in & SM_MASK;
        end else begin
          pc <= npc;
        end
      end
    end
  end

  // repeat-loop registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_on    <= 1'b0;
      rpt_start <= '0;
      rpt_end   <= '0;
      rpt_left  <= '0;
    end else if (loop_set) begin
      rpt_on    <= 1'b1;
      rpt_start <= loop_start;
      rpt_end   <= loop_end;
      rpt_left  <= loop_count;
    end else if (finish && rpt_dec) begin
      rpt_left <= rpt_left - RC_ONE;
      if (rpt_done) rpt_on <= 1'b0;
    end
  end

  assign cnt_inc[0] = finish;
  assign cnt_inc[1] = accept;
  assign cnt_inc[2] = finish && (st == ST_OP1) && (mode_q == MODE_PRED) && !ex_cond;
  assign cnt_inc[3] = finish && (st == ST_OP1) && (mode_q == MODE_SEQ) && ex_taken;

  dsd_counters #(.NUM(4), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .cnt(cnt_vec)
  );

  assign cnt_words       = cnt_vec[0];
  assign cnt_issued      = cnt_vec[1];
  assign cnt_skip_cond   = cnt_vec[2];
  assign cnt_skip_branch = cnt_vec[3];
endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
  parameter int PC_W   = 16,
  parameter int STAT_W = 16,
  parameter int CNT_W  = 32,
  parameter int OP_W   = 30,
  parameter int SM_BIT = 15,
  parameter logic [PC_W-1:0] TRAP_VEC = 16'h0040
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              ex_valid,
  input logic              ex_ready,
  input logic [OP_W-1:0]   ex_op,
  input logic              ex_long,
  input logic              ex_exc,
  input logic              halted,
  input logic              resume,
  input logic [PC_W-1:0]   pc,
  input logic              stat_wr,
  input logic [STAT_W-1:0] stat_wdata,
  input logic [CNT_W-1:0]  cnt_issued,
  input logic [CNT_W-1:0]  cnt_words
);
  localparam logic [STAT_W-1:0] SM_MASK = STAT_W'(1) << SM_BIT;

  p_hold_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !ex_ready) |=> (ex_valid && $stable(ex_op)));

  p_no_fetch_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |-> !in_ready);

  p_exc_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ready && ex_exc) |=> halted);

  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !resume) |=> (halted && $stable(pc)));

  p_long_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ready && ex_long) |=> (in_ready || halted));

  p_trap_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |-> (pc == TRAP_VEC && (stat_wdata & ~SM_MASK) == '0));

  p_cnt_mono_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (cnt_issued >= $past(cnt_issued) && cnt_words >= $past(cnt_words)));
endmodule

bind dual_slot_dispatch dsd_checker #(
  .PC_W(PC_W), .STAT_W(STAT_W), .CNT_W(CNT_W), .OP_W(OP_W),
  .SM_BIT(SM_BIT), .TRAP_VEC(TRAP_VEC)
) u_dsd_checker (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .ex_valid(ex_valid),
  .ex_ready(ex_ready), .ex_op(ex_op), .ex_long(ex_long), .ex_exc(ex_exc),
  .halted(halted), .resume(resume), .pc(pc), .stat_wr(stat_wr),
  .stat_wdata(stat_wdata), .cnt_issued(cnt_issued), .cnt_words(cnt_words)
);

// File: tb/test_dual_slot_dispatch.sv
`timescale 1ns/1ps
module test_dual_slot_dispatch;
  localparam int PC_W = 16, RC_W = 16, STAT_W = 16, CNT_W = 32, OP_W = 30;
  localparam logic [PC_W-1:0] TRAP = 16'h0040;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_ready;
  logic [31:0] in_word = '0;
  logic [PC_W+1:0] fetch_addr;
  logic [PC_W-1:0] pc;
  logic ex_valid, ex_ready = 0, ex_long, ex_slot, ex_pred;
  logic [OP_W-1:0] ex_op;
  logic ex_taken = 0, ex_cond = 0, ex_exc = 0;
  logic [PC_W-1:0] ex_target = '0;
  logic halted, resume = 0, loop_set = 0;
  logic [PC_W-1:0] loop_start = '0, loop_end = '0, bp_addr = '0;
  logic [RC_W-1:0] loop_count = '0;
  logic dbg_en = 0;
  logic [STAT_W-1:0] stat_in = '0, stat_wdata, trap_stat;
  logic stat_wr;
  logic [PC_W-1:0] trap_pc;
  logic [CNT_W-1:0] cnt_words, cnt_issued, cnt_skip_cond, cnt_skip_branch;

  always #4 clk = ~clk;

  dual_slot_dispatch i_dual_slot_dispatch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .fetch_addr(fetch_addr), .pc(pc), .ex_valid(ex_valid),
    .ex_ready(ex_ready), .ex_op(ex_op), .ex_long(ex_long), .ex_slot(ex_slot),
    .ex_pred(ex_pred), .ex_taken(ex_taken), .ex_target(ex_target),
    .ex_cond(ex_cond), .ex_exc(ex_exc), .halted(halted), .resume(resume),
    .loop_set(loop_set), .loop_start(loop_start), .loop_end(loop_end),
    .loop_count(loop_count), .dbg_en(dbg_en), .bp_addr(bp_addr),
    .stat_in(stat_in), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .trap_pc(trap_pc), .trap_stat(trap_stat), .cnt_words(cnt_words),
    .cnt_issued(cnt_issued), .cnt_skip_cond(cnt_skip_cond),
    .cnt_skip_branch(cnt_skip_branch)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int exp_words = 0, exp_issued = 0, exp_scond = 0, exp_sbr = 0;

  // responses per operation index, and what was issued
  logic r_taken[2], r_cond[2], r_exc[2];
  logic [PC_W-1:0] r_tgt[2];
  logic [OP_W-1:0] g_op[4];
  logic g_slot[4], g_long[4], g_pred[4];
  int n_ops;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_rsp();
    for (int i = 0; i < 2; i++) begin
      r_taken[i] = 0; r_cond[i] = 0; r_exc[i] = 0; r_tgt[i] = '0;
    end
  endtask

  task automatic run_word(input logic [31:0] w, input int stall);
    int stalled = 0;
    logic [OP_W-1:0] held = '0;
    n_ops = 0;
    @(negedge clk);
    in_word = w; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    for (int guard = 0; guard < 40; guard++) begin
      if (halted || in_ready) break;
      if (ex_valid) begin
        if (n_ops == 0 && stalled < stall) begin
          if (stalled == 0) held = ex_op;
          else chk("R12 op stable under stall", ex_op, held);
          chk("R12 no fetch while issuing", in_ready, 0);
          ex_ready = 0;
          stalled++;
        end else begin
          g_op[n_ops] = ex_op; g_slot[n_ops] = ex_slot;
          g_long[n_ops] = ex_long; g_pred[n_ops] = ex_pred;
          ex_taken = r_taken[n_ops < 2 ? n_ops : 1];
          ex_target = r_tgt[n_ops < 2 ? n_ops : 1];
          ex_cond = r_cond[n_ops < 2 ? n_ops : 1];
          ex_exc = r_exc[n_ops < 2 ? n_ops : 1];
          ex_ready = 1;
          if (n_ops < 3) n_ops++;
        end
      end
      @(negedge clk);
      ex_ready = 0; ex_taken = 0; ex_exc = 0; ex_cond = 0;
    end
    exp_issued += n_ops;
    if (!halted) exp_words++;
  endtask

  function automatic logic [31:0] shorts(input logic [1:0] f, input logic [14:0] l, input logic [14:0] r);
    return {f, l, r};
  endfunction

  function automatic logic [31:0] longw(input logic [29:0] v);
    return {2'b11, v};
  endfunction

  task automatic t_reset();
    chk("R1 pc", pc, 16'hFFC0);
    chk("R1 fetch_addr", fetch_addr, 18'h3FF00);
    chk("R1 counters", {cnt_words, cnt_issued, cnt_skip_cond, cnt_skip_branch}, 0);
    chk("R1 idle", {ex_valid, halted, in_ready}, 3'b001);
  endtask

  task automatic t_long();
    clear_rsp();
    run_word(longw(30'h2ABC1234), 0);
    chk("R2 one op", n_ops, 1);
    chk("R2 op bits", g_op[0], 30'h2ABC1234);
    chk("R2 long flag", g_long[0], 1);
    chk("R7 pc+1", pc, 16'hFFC1);
    chk("R7 fetch_addr", fetch_addr, 18'h3FF04);
  endtask

  task automatic t_right_first();
    clear_rsp();
    run_word(shorts(2'b10, 15'h1234, 15'h0456), 2);
    chk("R3 two ops", n_ops, 2);
    chk("R3 first right", {g_op[0], g_slot[0], g_long[0]}, {30'h0456, 1'b1, 1'b0});
    chk("R3 second left", {g_op[1], g_slot[1]}, {30'h1234, 1'b0});
    chk("R7 pc", pc, 16'hFFC2);
  endtask

  task automatic t_left_first();
    clear_rsp();
    r_taken[0] = 1; r_tgt[0] = 16'h0100;
    run_word(shorts(2'b01, 15'h0321, 15'h0654), 0);
    exp_sbr++;
    chk("R4 branch cancels second", n_ops, 1);
    chk("R3 left first", {g_op[0], g_slot[0]}, {30'h0321, 1'b0});
    chk("R7 branch target", pc, 16'h0100);
    clear_rsp();
    run_word(shorts(2'b01, 15'h0321, 15'h0654), 0);
    chk("R3 left then right", {g_op[0], g_slot[0], g_op[1], g_slot[1]},
        {30'h0321, 1'b0, 30'h0654, 1'b1});
    chk("R7 pc", pc, 16'h0101);
  endtask

  task automatic t_seq_exc();
    clear_rsp();
    r_exc[0] = 1;
    run_word(shorts(2'b10, 15'h0111, 15'h0222), 0);
    chk("R4 exception cancels second", n_ops, 1);
    chk("R11 halted", halted, 1);
    repeat (3) @(negedge clk);
    chk("R11 pc held", pc, 16'h0101);
    chk("R11 no issue", {ex_valid, in_ready}, 0);
    resume = 1; @(negedge clk); resume = 0;
    chk("R11 resumed", {halted, in_ready}, 2'b01);
    chk("R11 same pc", pc, 16'h0101);
  endtask

  task automatic t_cond();
    clear_rsp();
    r_cond[0] = 1;
    run_word(shorts(2'b00, 15'h0111, 15'h3C12), 0);
    chk("R5 right test first", {g_op[0], g_slot[0], g_pred[0]}, {30'h3C12, 1'b1, 1'b0});
    chk("R5 partner predicated", {g_op[1], g_slot[1], g_pred[1]}, {30'h0111, 1'b0, 1'b1});
    chk("R7 pc", pc, 16'h0102);
    clear_rsp();
    run_word(shorts(2'b00, 15'h0111, 15'h3C12), 0);
    exp_scond++;
    chk("R5 false skips partner", n_ops, 1);
    chk("R5 skip count", cnt_skip_cond, exp_scond);
    clear_rsp();
    r_cond[0] = 1;
    run_word(shorts(2'b00, 15'h3C55, 15'h0222), 0);
    chk("R5 left test first", {g_op[0], g_slot[0], g_op[1], g_slot[1], g_pred[1]},
        {30'h3C55, 1'b0, 30'h0222, 1'b1, 1'b1});
    chk("R7 pc", pc, 16'h0104);
  endtask

  task automatic t_parallel();
    clear_rsp();
    r_exc[0] = 1;
    run_word(shorts(2'b00, 15'h0111, 15'h0222), 0);
    chk("R6 left exception stops right", {n_ops[1:0], g_slot[0]}, {2'd1, 1'b0});
    resume = 1; @(negedge clk); resume = 0;
    clear_rsp();
    r_taken[0] = 1; r_tgt[0] = 16'h0200;
    r_taken[1] = 1; r_tgt[1] = 16'h0300;
    run_word(shorts(2'b00, 15'h0111, 15'h0222), 0);
    chk("R6 left then right", {g_slot[0], g_slot[1], g_pred[1], n_ops[1:0]},
        {1'b0, 1'b1, 1'b0, 2'd2});
    chk("R7 last taken wins", pc, 16'h0300);
  endtask

  task automatic t_loop();
    clear_rsp();
    @(negedge clk);
    loop_start = 16'h0300; loop_end = 16'h0301; loop_count = 2; loop_set = 1;
    @(negedge clk); loop_set = 0;
    run_word(longw(30'h1), 0); chk("R8 step to end", pc, 16'h0301);
    run_word(longw(30'h1), 0); chk("R8 back to start", pc, 16'h0300);
    run_word(longw(30'h1), 0); chk("R8 step to end again", pc, 16'h0301);
    run_word(longw(30'h1), 0); chk("R8 exit after count", pc, 16'h0302);
    run_word(longw(30'h1), 0); chk("R8 disarmed", pc, 16'h0303);
  endtask

  task automatic t_branch_end();
    @(negedge clk);
    loop_start = 16'h0303; loop_end = 16'h0308; loop_count = 2; loop_set = 1;
    @(negedge clk); loop_set = 0;
    clear_rsp(); r_taken[0] = 1; r_tgt[0] = 16'h0308;
    run_word(longw(30'h2), 0); chk("R9 branch lands on end", pc, 16'h0308);
    clear_rsp();
    run_word(longw(30'h2), 0); chk("R9 first real iteration", pc, 16'h0303);
    clear_rsp(); r_taken[0] = 1; r_tgt[0] = 16'h0308;
    run_word(longw(30'h2), 0); chk("R9 branch again", pc, 16'h0308);
    clear_rsp();
    run_word(longw(30'h2), 0); chk("R9 count not spent by branch", pc, 16'h0309);
    run_word(longw(30'h2), 0); chk("R8 loop off", pc, 16'h030A);
  endtask

  task automatic t_break();
    clear_rsp();
    dbg_en = 1; bp_addr = 16'h030A; stat_in = 16'hA5A5;
    run_word(shorts(2'b01, 15'h0111, 15'h0222), 0);
    chk("R10 pc to vector", pc, TRAP);
    chk("R10 saved next pc", trap_pc, 16'h030B);
    chk("R10 saved status", trap_stat, 16'hA5A5);
    chk("R10 status write", {stat_wr, stat_wdata}, {1'b1, 16'h8000});
    @(negedge clk);
    chk("R10 single pulse", stat_wr, 0);
    dbg_en = 0;
    run_word(longw(30'h3), 0);
    chk("R10 runs from vector", pc, TRAP + 16'h1);
  endtask

  task automatic t_counters();
    chk("R13 words", cnt_words, exp_words);
    chk("R13 issued", cnt_issued, exp_issued);
    chk("R4 branch skips", cnt_skip_branch, exp_sbr);
    chk("R5 cond skips", cnt_skip_cond, exp_scond);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_long();
    t_right_first();
    t_left_first();
    t_seq_exc();
    t_cond();
    t_parallel();
    t_loop();
    t_branch_end();
    t_break();
    t_counters();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule